// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This unit sits between the execution datapath of a small 8-bit accumulator controller and its 512-byte register space. Each access forms a 9-bit location in one of two ways. A nonzero 7-bit file field from the instruction is joined under a 2-bit bank number held in the status register. A file field of zero selects a phantom register that has no storage of its own. The access is then steered through an 8-bit pointer register, with a single high-order bank bit, also from the status register, placed above it.

Reads are combinational from the file field. Writes commit on the rising clock edge. The status register and the pointer are ordinary mapped locations at fixed offsets in every bank. Software can therefore move between banks and step the pointer with plain register writes. An indirect access that lands back on the phantom offset reads zero and writes nothing.

Top module: `regfile_addr_unit`

## Requirements
- R1: When `file_sel` is nonzero, `eff_addr` equals {status bit 6, status bit 5, `file_sel`} and `via_ptr` is low.
- R2: When `file_sel` is zero, `via_ptr` is high and `eff_addr` equals {status bit 7, pointer}.
- R3: Every 9-bit location whose low 7 bits are not 0, 3 or 4 holds its own byte, independent of the other three banks.
- R4: An access through the pointer whose `eff_addr` has low 7 bits of zero raises `null_access` and returns `rd_data` = 00h.
- R5: A write with `null_access` high changes neither the status register, the pointer nor any stored byte.
- R6: The pointer is read and written at offset 04h of every bank, and a new value steers indirect accesses from the next cycle onward. The access in the writing cycle still uses the old value.
- R7: The status register is read and written at offset 03h of every bank. Bit 7 is the indirect bank bit, bits 6:5 are the direct bank number, and bits 4:0 are plain storage. A write takes effect from the next cycle.
- R8: `rd_data` follows the addressed location combinationally. With `wr_en` low, a clock edge changes nothing.
- R9: A synchronous reset clears the status register and the pointer to 00h.
- R10: Software can clear locations 20h to 2Fh by repeatedly writing through the phantom register and incrementing the pointer. Locations 1Fh and 30h are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| file_sel | input | 7 | Register field of the current instruction |
| wr_en | input | 1 | Commit `wr_data` to the addressed location at the clock edge |
| wr_data | input | 8 | Write data from the datapath |
| rd_data | output | 8 | Combinational read data of the addressed location |
| eff_addr | output | 9 | Effective location of the current access |
| via_ptr | output | 1 | Access was formed through the pointer |
| null_access | output | 1 | Pointer lands on the phantom offset |

## Verification
The interesting collision is an indirect write whose target is one of the two registers that form the indirect address. This happens when the pointer holds 04h or 03h and the write goes through the phantom register. The bench sets up both cases. In the writing cycle, it checks that `eff_addr` and `rd_data` still reflect the old pointer or status value. After the edge, it reads back and checks that the new value now steers the next access. Full sweeps of direct offsets in all four banks, and of all 512 pointer and bank-bit combinations, are compared against an arithmetic model in the bench.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 7;
  localparam int BANK_W = 2;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  typedef enum logic [1:0] {TGT_NONE, TGT_STATUS, TGT_PTR, TGT_MEM} tgt_e;

  // Bank number placed above the instruction's register field.
  function automatic addr_t direct_addr(input bank_t bank, input ofs_t ofs);
    return {bank, ofs};
  endfunction

  // Single bank bit placed above the full pointer.
  function automatic addr_t indirect_addr(input logic hi, input ptr_t ptr);
    return {hi, ptr};
  endfunction

  function automatic ofs_t offset_of(input addr_t a);
    return a[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/bfa_ctrl_regs.sv
module bfa_ctrl_regs
  import bfa_pkg::*;
#(
  parameter int IRP_BIT = 7,
  parameter int RP_LO   = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we_status,
  input  logic  we_ptr,
  input  byte_t wr_data,
  output byte_t status_q,
  output ptr_t  ptr_q,
  output logic  irp,
  output bank_t rp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (we_status) status_q <= wr_data;
      if (we_ptr)    ptr_q    <= wr_data[PTR_W-1:0];
    end
  end

  assign irp = status_q[IRP_BIT];
  assign rp  = status_q[RP_LO+BANK_W-1:RP_LO];

  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (status_q == '0 && ptr_q == '0));

  assert_ptr_write_lag_R6: assert property (@(posedge clk) disable iff (rst)
    we_ptr |=> ptr_q == $past(wr_data[PTR_W-1:0]));

  assert_status_write_lag_R7: assert property (@(posedge clk) disable iff (rst)
    we_status |=> status_q == $past(wr_data));
endmodule

// File: rtl/bfa_addr_gen.sv
module bfa_addr_gen
  import bfa_pkg::*;
#(
  parameter ofs_t PHANTOM_OFS = 7'h00,
  parameter ofs_t STATUS_OFS  = 7'h03,
  parameter ofs_t PTR_OFS     = 7'h04
) (
  input  ofs_t  file_sel,
  input  bank_t rp,
  input  logic  irp,
  input  ptr_t  ptr,
  output addr_t eff_addr,
  output logic  via_ptr,
  output logic  null_hit,
  output tgt_e  tgt
);
  ofs_t ofs;

  always_comb begin
    via_ptr  = (file_sel == PHANTOM_OFS);
    eff_addr = via_ptr ? indirect_addr(irp, ptr) : direct_addr(rp, file_sel);
    ofs      = offset_of(eff_addr);
    null_hit = via_ptr && (ofs == PHANTOM_OFS);
    if (ofs == PHANTOM_OFS)     tgt = TGT_NONE;
    else if (ofs == STATUS_OFS) tgt = TGT_STATUS;
    else if (ofs == PTR_OFS)    tgt = TGT_PTR;
    else                        tgt = TGT_MEM;
  end
endmodule

// File: rtl/bfa_store.sv
module bfa_store
  import bfa_pkg::*;
#(
  parameter bit CLEAR_ON_RESET = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  addr_t addr,
  input  byte_t wdata,
  output byte_t rdata
);
  byte_t mem [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
          mem[addr] <= wdata;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (we && !rst) mem[addr] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[addr];

  assert_store_readback_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> (!($stable(addr))) || rdata == $past(wdata));
endmodule

// File: rtl/regfile_addr_unit.sv
module regfile_addr_unit
  import bfa_pkg::*;
#(
  parameter ofs_t STATUS_OFS     = 7'h03,
  parameter ofs_t PTR_OFS        = 7'h04,
  parameter int   IRP_BIT        = 7,
  parameter int   RP_LO          = 5,
  parameter bit   CLEAR_ON_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  file_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              via_ptr,
  output logic              null_access
);
  localparam ofs_t PHANTOM_OFS = '0;

  byte_t status_q;
  ptr_t  ptr_q;
  logic  irp;
  bank_t rp;
  tgt_e  tgt;
  byte_t mem_rdata;
  logic  we_status, we_ptr, we_mem;

  bfa_ctrl_regs #(.IRP_BIT(IRP_BIT), .RP_LO(RP_LO)) u_ctrl (
    .clk(clk), .rst(rst), .we_status(we_status), .we_ptr(we_ptr),
    .wr_data(wr_data), .status_q(status_q), .ptr_q(ptr_q), .irp(irp), .rp(rp)
  );

  bfa_addr_gen #(
    .PHANTOM_OFS(PHANTOM_OFS), .STATUS_OFS(STATUS_OFS), .PTR_OFS(PTR_OFS)
  ) u_agen (
    .file_sel(file_sel), .rp(rp), .irp(irp), .ptr(ptr_q),
    .eff_addr(eff_addr), .via_ptr(via_ptr), .null_hit(null_access), .tgt(tgt)
  );

  bfa_store #(.CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
    .clk(clk), .rst(rst), .we(we_mem), .addr(eff_addr),
    .wdata(wr_data), .rdata(mem_rdata)
  );

  // Write steering: the phantom offset owns no storage.
  assign we_status = wr_en && (tgt == TGT_STATUS);
  assign we_ptr    = wr_en && (tgt == TGT_PTR);
  assign we_mem    = wr_en && (tgt == TGT_MEM);

  always_comb begin
    unique case (tgt)
      TGT_STATUS: rd_data = status_q;
      TGT_PTR:    rd_data = ptr_q;
      TGT_MEM:    rd_data = mem_rdata;
      default:    rd_data = '0;
    endcase
  end

  assert_direct_form_R1: assert property (@(posedge clk) disable iff (rst)
    (file_sel != PHANTOM_OFS) |-> (!via_ptr && eff_addr == {rp, file_sel}));

  assert_indirect_form_R2: assert property (@(posedge clk) disable iff (rst)
    (file_sel == PHANTOM_OFS) |-> (via_ptr && eff_addr == {irp, ptr_q}));

  assert_null_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    null_access |-> rd_data == '0);

  assert_null_write_inert_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && null_access) |=> ($stable(status_q) && $stable(ptr_q)));

  assert_single_target_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we_status, we_ptr, we_mem}) && !(null_access && (we_status || we_ptr || we_mem)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(status_q) && $stable(ptr_q)));
endmodule

// File: tb/regfile_addr_unit_test.sv
`timescale 1ns/1ps
module regfile_addr_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] file_sel = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [8:0] eff_addr;
  logic       via_ptr;
  logic       null_access;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mem_m [512];
  logic [7:0] st_m  = '0;
  logic [7:0] ptr_m = '0;

  regfile_addr_unit uut (
    .clk(clk), .rst(rst), .file_sel(file_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eff_addr(eff_addr), .via_ptr(via_ptr), .null_access(null_access)
  );

  always #2 clk = ~clk;

  function automatic logic [8:0] m_eff(input logic [6:0] sel);
    if (sel == 7'd0) return {st_m[7], ptr_m};
    return {st_m[6:5], sel};
  endfunction

  function automatic logic [7:0] m_read(input logic [8:0] e);
    case (e[6:0])
      7'd0:    return 8'h00;
      7'd3:    return st_m;
      7'd4:    return ptr_m;
      default: return mem_m[e];
    endcase
  endfunction

  function automatic logic [7:0] pat(input logic [8:0] e);
    return e[7:0] ^ {e[8], 7'h35};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [6:0] sel, input string req);
    logic [8:0] e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'hA5; file_sel = sel;
    e = m_eff(sel);
    #1;
    chk(req, rd_data, m_read(e));
    chk(req, eff_addr, e);
    chk(req, via_ptr, sel == 7'd0);
    chk(req, null_access, (sel == 7'd0) && (e[6:0] == 7'd0));
  endtask

  task automatic put(input logic [6:0] sel, input logic [7:0] d);
    logic [8:0] e;
    @(negedge clk);
    file_sel = sel; wr_data = d; wr_en = 1'b1;
    e = m_eff(sel);
    @(posedge clk);
    case (e[6:0])
      7'd0: ;
      7'd3: st_m = d;
      7'd4: ptr_m = d;
      default: mem_m[e] = d;
    endcase
    #1 wr_en = 1'b0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9: reset state of status and pointer
    look(7'd3, "R9");
    look(7'd4, "R9");

    // R1 / R3: fill every ordinary location of all four banks directly
    for (int b = 0; b < 4; b++) begin
      put(7'd3, {1'b0, 2'(b), 5'h00});
      for (int o = 1; o < 128; o++) begin
        if (o != 3 && o != 4) put(7'(o), pat({2'(b), 7'(o)}));
      end
    end
    for (int b = 0; b < 4; b++) begin
      put(7'd3, {1'b1, 2'(b), 5'h0A});
      for (int o = 1; o < 128; o++) look(7'(o), (o == 3 || o == 4) ? "R7" : "R1 R3");
    end

    // R2 / R4: every pointer value under both indirect bank bits
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 256; p++) begin
        put(7'd3, {1'(h), 2'(p & 3), 5'h11});
        put(7'd4, 8'(p));
        look(7'd0, ((p & 8'h7F) == 0) ? "R4" : "R2");
      end
    end

    // R5: writes landing on the phantom offset change nothing
    put(7'd3, 8'h00);
    put(7'd4, 8'h00);
    put(7'd0, 8'hEE);
    look(7'd3, "R5");
    look(7'd4, "R5");
    look(7'd0, "R5");
    put(7'd3, 8'h9F);
    put(7'd4, 8'h80);
    put(7'd0, 8'h5D);
    look(7'd3, "R5");
    look(7'd4, "R5");
    look(7'd0, "R5");
    look(7'd1, "R5");

    // R6: write the pointer through itself; old value steers this cycle
    put(7'd3, 8'h00);
    put(7'd4, 8'h04);
    @(negedge clk);
    file_sel = 7'd0; wr_data = 8'h33; wr_en = 1'b1;
    #1;
    chk("R6", rd_data, 8'h04);
    chk("R6", eff_addr, 9'h004);
    @(posedge clk);
    ptr_m = 8'h33;
    #1 wr_en = 1'b0;
    look(7'd4, "R6");
    look(7'd0, "R6");

    // R7: write status through the pointer; new bank bits apply next cycle
    put(7'd4, 8'h03);
    @(negedge clk);
    file_sel = 7'd0; wr_data = 8'h80; wr_en = 1'b1;
    #1;
    chk("R7", rd_data, 8'h00);
    chk("R7", eff_addr, 9'h003);
    @(posedge clk);
    st_m = 8'h80;
    #1 wr_en = 1'b0;
    look(7'd0, "R7");
    put(7'd3, 8'h4C);
    look(7'd5, "R7");
    look(7'd3, "R7");

    // R8: disabled write leaves the location alone
    @(negedge clk);
    file_sel = 7'h10; wr_data = ~m_read(m_eff(7'h10)); wr_en = 1'b0;
    @(posedge clk);
    look(7'h10, "R8");

    // R10: clear 20h..2Fh by stepping the pointer
    put(7'd3, 8'h00);
    for (int a = 8'h1F; a <= 8'h30; a++) put(7'(a), 8'h77);
    put(7'd4, 8'h20);
    for (int i = 0; i < 16; i++) begin
      put(7'd0, 8'h00);
      put(7'd4, ptr_m + 8'd1);
    end
    look(7'd4, "R10");
    for (int a = 8'h1F; a <= 8'h30; a++) begin
      look(7'(a), "R10");
      chk("R10", rd_data, (a == 8'h1F || a == 8'h30) ? 8'h77 : 8'h00);
    end

    // R9: reset in the middle of operation
    put(7'd3, 8'hFF);
    put(7'd4, 8'h9C);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    st_m = 8'h00; ptr_m = 8'h00;
    @(negedge clk) rst = 1'b0;
    look(7'd3, "R9");
    look(7'd4, "R9");

    finish_up();
  end
endmodule